// File: doc/BRIEF.md
# Two-Level Branch Target Predictor

This block supplies the target address for a branch that the fetch stage has already predicted taken. It keeps a small, fast first-level table of recently used branch/target pairs in front of a much larger second-level table, in the same way an L1 cache sits in front of an L2. A lookup always searches the first level. Only when that search misses is the second level searched. A second-level hit copies the pair into the first level, so a branch that is reused is again served from the small table. When neither level knows the branch, the block returns no prediction, together with the sequential address so that fetch can fall through.

Each table is set-associative. An entry holds the branch address tag and the last observed target. Replacement within a set is least-recently-used, and recency is refreshed by lookup hits, refills and updates. The resolution stage writes the observed target of every taken branch into both levels through a plain update port. A new target replaces a stale one.

The lookup request is a valid/ready stream. The request is accepted on a cycle where `lk_valid` and `lk_ready` are both high. A requester that sees `lk_ready` low must hold `lk_valid` and `lk_pc` until acceptance. `lk_ready` is low for exactly one cycle after a first-level miss, while the second level is being read. The response is a one-cycle pulse and carries no back-pressure, because fetch always consumes it. The update port is always accepted.

Top module: `btb_two_level`

## Requirements
- R1: After reset every entry in both levels is invalid. `lk_ready` is 1, `rsp_valid` is 0, and any lookup made before the first update reports no prediction.
- R2: An accepted lookup that hits the first level raises `rsp_valid` on the next cycle with `rsp_hit`=1, `rsp_late`=0 and the stored target.
- R3: An accepted lookup that misses the first level drives `lk_ready` low on the next cycle. The response follows one cycle later with `rsp_late`=1, carrying the second-level result.
- R4: A second-level hit writes the pair into the first level, so a later lookup of that branch answers with `rsp_late`=0.
- R5: When both levels miss, the response has `rsp_hit`=0, `rsp_late`=1 and `rsp_target` = lookup address + SEQ_STEP (4 by default).
- R6: An update writes the address/target pair into both levels. If the address is already stored, only its target is replaced and no duplicate entry is made. A later lookup returns the newest target.
- R7: The first-level set index is the low log2(L1_SETS) bits of the address. When a full set receives a new branch, the least recently used entry of that set is evicted, while that entry stays reachable in the second level.
- R8: The second-level set index is the low log2(L2_SETS) bits of the address. A full set evicts its least recently used entry, and a lookup of the evicted branch then misses both levels.
- R9: Each level performs one write or recency change per cycle, with the update first, then the refill, then the lookup hit. A refill or recency change that loses this priority is dropped. A lookup reads the table contents from before the same cycle's update.
- R10: A request held with `lk_valid` high while `lk_ready` is low is not taken. It is accepted on the first cycle `lk_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, invalidates both levels |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Block can take a lookup this cycle |
| lk_pc | input | ADDR_W | Branch address to look up |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | A target was found |
| rsp_late | output | 1 | Response came via the second level |
| rsp_target | output | ADDR_W | Predicted target, or sequential address on a miss |
| upd_valid | input | 1 | Resolved taken branch |
| upd_pc | input | ADDR_W | Resolved branch address |
| upd_target | input | ADDR_W | Observed target |

## Verification
The assertions rely on the requester obeying the stream rule: it holds `lk_valid` and `lk_pc` steady while `lk_ready` is low. They also assume that address inputs are never unknown, because the tables are searched on `lk_pc` and `upd_pc` every cycle. The stimulus is driven at the falling edge from a model that tracks `lk_ready`, so a held request keeps its address. Addresses come from a small pool that crowds a few sets, which forces evictions, refills and same-cycle collisions between updates and lookups.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic {
    SEQ_FIRST  = 1'b0,
    SEQ_SECOND = 1'b1
  } seq_st_t;
endpackage

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][WAY_W-1:0]  age_i,
  output logic [WAY_W-1:0]            way_o
);
  // oldest valid way, overridden by the lowest-numbered invalid way
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (age_i[w] == WAY_W'(WAYS - 1)) way_o = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_i[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              op_en,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_pc,
  input  logic [ADDR_W-1:0] op_target
);
  logic [TAG_W-1:0]            tag_q [SETS][WAYS];
  logic [ADDR_W-1:0]           tgt_q [SETS][WAYS];
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

  logic [IDX_W-1:0] rd_set, op_set;
  logic [TAG_W-1:0] rd_tag, op_tag;
  logic [WAYS-1:0]  rd_match, op_match;
  logic             op_hit;
  logic [WAY_W-1:0] hit_way, victim_way, sel_way;
  logic             do_op;

  assign rd_set = rd_pc[IDX_W-1:0];
  assign rd_tag = rd_pc[ADDR_W-1:IDX_W];
  assign op_set = op_pc[IDX_W-1:0];
  assign op_tag = op_pc[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign rd_match[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    assign op_match[w] = vld_q[op_set][w] && (tag_q[op_set][w] == op_tag);
  end

  assign rd_hit = |rd_match;
  assign op_hit = |op_match;

  always_comb begin
    rd_target = '0;
    for (int w = 0; w < WAYS; w++)
      if (rd_match[w]) rd_target = rd_target | tgt_q[rd_set][w];
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (op_match[w]) hit_way = WAY_W'(w);
  end

  btb_victim #(.WAYS(WAYS)) u_victim (
    .vld_i (vld_q[op_set]),
    .age_i (age_q[op_set]),
    .way_o (victim_way)
  );

  assign sel_way = op_hit ? hit_way : victim_way;
  // a touch of an absent branch changes nothing
  assign do_op   = op_en && (op_wr || op_hit);

  always_ff @(posedge clk) begin
    if (op_en && op_wr) begin
      tag_q[op_set][sel_way] <= op_tag;
      tgt_q[op_set][sel_way] <= op_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (do_op) begin
      if (op_wr) vld_q[op_set][sel_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)
          age_q[op_set][w] <= '0;
        else if (age_q[op_set][w] < age_q[op_set][sel_way])
          age_q[op_set][w] <= age_q[op_set][w] + 1'b1;
      end
    end
  end

  // write-back check: a written branch must be present on the next cycle
  logic              chk_pend_q;
  logic [ADDR_W-1:0] chk_pc_q;
  logic              chk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_pend_q <= 1'b0;
      chk_pc_q   <= '0;
    end else begin
      chk_pend_q <= op_en && op_wr;
      chk_pc_q   <= op_pc;
    end
  end

  always_comb begin
    chk_hit = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[chk_pc_q[IDX_W-1:0]][w] &&
          tag_q[chk_pc_q[IDX_W-1:0]][w] == chk_pc_q[ADDR_W-1:IDX_W])
        chk_hit = 1'b1;
  end

  // R6
  written_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend_q |-> chk_hit);

  // R6
  no_duplicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match));
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEQ_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_ready,
  input  logic              upd_valid,
  input  logic              l1_hit,
  input  logic [ADDR_W-1:0] l1_target,
  input  logic              l2_hit,
  input  logic [ADDR_W-1:0] l2_target,
  output logic [ADDR_W-1:0] pend_pc,
  output logic              l1_touch,
  output logic              refill,
  output logic              l2_touch,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_late,
  output logic [ADDR_W-1:0] rsp_target
);
  seq_st_t st_q;
  logic    accept, in_second;

  assign lk_ready  = (st_q == SEQ_FIRST);
  assign in_second = (st_q == SEQ_SECOND);
  assign accept    = lk_valid && lk_ready;
  assign l1_touch  = accept && l1_hit;
  assign refill    = in_second && l2_hit && !upd_valid;
  assign l2_touch  = in_second && l2_hit && !upd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SEQ_FIRST;
      pend_pc    <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_late   <= 1'b0;
      rsp_target <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        SEQ_FIRST: begin
          if (accept) begin
            if (l1_hit) begin
              rsp_valid  <= 1'b1;
              rsp_hit    <= 1'b1;
              rsp_late   <= 1'b0;
              rsp_target <= l1_target;
            end else begin
              st_q    <= SEQ_SECOND;
              pend_pc <= lk_pc;
            end
          end
        end
        SEQ_SECOND: begin
          st_q       <= SEQ_FIRST;
          rsp_valid  <= 1'b1;
          rsp_late   <= 1'b1;
          rsp_hit    <= l2_hit;
          rsp_target <= l2_hit ? l2_target : pend_pc + ADDR_W'(SEQ_STEP);
        end
        default: st_q <= SEQ_FIRST;
      endcase
    end
  end

  // R2
  fast_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && l1_hit |=> rsp_valid && rsp_hit && !rsp_late);

  // R3
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !l1_hit |=> !lk_ready && !rsp_valid);

  // R3
  late_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |=> rsp_valid && rsp_late && lk_ready);

  // R5
  miss_is_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_late);

  // R10
  held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready && lk_valid |=> lk_ready);
endmodule

// File: rtl/btb_two_level.sv
module btb_two_level #(
  parameter int ADDR_W   = 32,
  parameter int L1_SETS  = 64,
  parameter int L1_WAYS  = 4,
  parameter int L2_SETS  = 512,
  parameter int L2_WAYS  = 4,
  parameter int SEQ_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_late,
  output logic [ADDR_W-1:0] rsp_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);
  logic              l1_hit, l2_hit;
  logic [ADDR_W-1:0] l1_target, l2_target, pend_pc;
  logic              l1_touch, refill, l2_touch;
  logic              l1_op_en, l1_op_wr, l2_op_en;
  logic [ADDR_W-1:0] l1_op_pc, l1_op_tgt, l2_op_pc;

  // one table operation per level per cycle: update, then refill, then touch
  assign l1_op_en  = upd_valid || refill || l1_touch;
  assign l1_op_wr  = upd_valid || refill;
  assign l1_op_pc  = upd_valid ? upd_pc : (refill ? pend_pc : lk_pc);
  assign l1_op_tgt = upd_valid ? upd_target : l2_target;
  assign l2_op_en  = upd_valid || l2_touch;
  assign l2_op_pc  = upd_valid ? upd_pc : pend_pc;

  btb_ctrl #(.ADDR_W(ADDR_W), .SEQ_STEP(SEQ_STEP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_pc      (lk_pc),
    .lk_ready   (lk_ready),
    .upd_valid  (upd_valid),
    .l1_hit     (l1_hit),
    .l1_target  (l1_target),
    .l2_hit     (l2_hit),
    .l2_target  (l2_target),
    .pend_pc    (pend_pc),
    .l1_touch   (l1_touch),
    .refill     (refill),
    .l2_touch   (l2_touch),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_late   (rsp_late),
    .rsp_target (rsp_target)
  );

  btb_table #(.ADDR_W(ADDR_W), .SETS(L1_SETS), .WAYS(L1_WAYS)) u_l1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pc     (lk_pc),
    .rd_hit    (l1_hit),
    .rd_target (l1_target),
    .op_en     (l1_op_en),
    .op_wr     (l1_op_wr),
    .op_pc     (l1_op_pc),
    .op_target (l1_op_tgt)
  );

  btb_table #(.ADDR_W(ADDR_W), .SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pc     (pend_pc),
    .rd_hit    (l2_hit),
    .rd_target (l2_target),
    .op_en     (l2_op_en),
    .op_wr     (upd_valid),
    .op_pc     (l2_op_pc),
    .op_target (upd_target)
  );

  // R4
  refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill |=> lk_ready);
endmodule

// File: tb/sim_btb_two_level.sv
module sim_btb_two_level;
  localparam int AW = 16;
  localparam int L1S = 4, L1W = 2, L2S = 8, L2W = 4, STEP = 4;

  typedef struct packed { logic [AW-1:0] pc; logic [AW-1:0] tg; } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, upd_valid = 1'b0;
  logic [AW-1:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_late;
  logic [AW-1:0] rsp_target;

  always #5 clk = ~clk;

  btb_two_level #(.ADDR_W(AW), .L1_SETS(L1S), .L1_WAYS(L1W), .L2_SETS(L2S),
                  .L2_WAYS(L2W), .SEQ_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_pc(lk_pc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_late(rsp_late),
    .rsp_target(rsp_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target));

  int tests = 0, fails = 0;
  string req = "R1";

  // reference model: per-level recency lists, most recent first
  ent_t q1[$], q2[$];
  bit   m_second = 0, m_acc = 0;
  logic [AW-1:0] m_pend = '0;
  bit   e_v = 0, e_h = 0, e_l = 0;
  logic [AW-1:0] e_t = '0;

  task automatic m_find(ref ent_t q[$], input logic [AW-1:0] pc,
                        output bit h, output logic [AW-1:0] t);
    h = 0; t = '0;
    foreach (q[i]) if (q[i].pc == pc) begin h = 1; t = q[i].tg; end
  endtask

  task automatic m_write(ref ent_t q[$], input int sets, input int ways,
                         input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    int idx = -1, cnt = 0, last = -1;
    foreach (q[i]) if (q[i].pc == pc) idx = i;
    if (idx >= 0) q.delete(idx);
    else begin
      foreach (q[i]) if (int'(q[i].pc) % sets == int'(pc) % sets) begin cnt++; last = i; end
      if (cnt == ways) q.delete(last);
    end
    q.push_front('{pc: pc, tg: tg});
  endtask

  task automatic m_touch(ref ent_t q[$], input logic [AW-1:0] pc);
    int idx = -1;
    ent_t e;
    foreach (q[i]) if (q[i].pc == pc) idx = i;
    if (idx >= 0) begin e = q[idx]; q.delete(idx); q.push_front(e); end
  endtask

  task automatic check(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare;
    check("lk_ready", AW'(lk_ready), AW'(!m_second));
    check("rsp_valid", AW'(rsp_valid), AW'(e_v));
    if (e_v) begin
      check("rsp_hit", AW'(rsp_hit), AW'(e_h));
      check("rsp_late", AW'(rsp_late), AW'(e_l));
      check("rsp_target", rsp_target, e_t);
    end
  endtask

  task automatic step;
    bit h;
    logic [AW-1:0] t;
    m_acc = 0; e_v = 0;
    if (!m_second) begin
      h = 0;
      if (lk_valid) begin
        m_acc = 1;
        m_find(q1, lk_pc, h, t);
        if (h) begin e_v = 1; e_h = 1; e_l = 0; e_t = t; end
        else begin m_second = 1; m_pend = lk_pc; end
      end
      if (upd_valid) m_write(q1, L1S, L1W, upd_pc, upd_target);
      else if (lk_valid && h) m_touch(q1, lk_pc);
      if (upd_valid) m_write(q2, L2S, L2W, upd_pc, upd_target);
    end else begin
      m_find(q2, m_pend, h, t);
      e_v = 1; e_l = 1; e_h = h; e_t = h ? t : m_pend + AW'(STEP);
      m_second = 0;
      if (upd_valid) m_write(q1, L1S, L1W, upd_pc, upd_target);
      else if (h) m_write(q1, L1S, L1W, m_pend, t);
      if (upd_valid) m_write(q2, L2S, L2W, upd_pc, upd_target);
      else if (h) m_touch(q2, m_pend);
    end
  endtask

  task automatic cyc(input bit lv, input logic [AW-1:0] lpc, input bit uv,
                     input logic [AW-1:0] upc, input logic [AW-1:0] utg);
    @(negedge clk);
    compare();
    lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_target = utg;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, lk_pc, 0, '0, '0);
  endtask

  task automatic look(input logic [AW-1:0] pc);
    cyc(1, pc, 0, '0, '0);
    idle(2);
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    cyc(0, lk_pc, 1, pc, tg);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit lv;
    logic [AW-1:0] lpc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle(2); look(16'h0100);
    req = "R5"; look(16'h0204);
    req = "R6"; upd(16'h0100, 16'hAAAA); look(16'h0100);
    upd(16'h0100, 16'hBBBB); look(16'h0100); look(16'h0100);
    req = "R2"; upd(16'h0021, 16'h1234); look(16'h0021); look(16'h0100);
    req = "R7"; upd(16'h0010, 16'h1010); upd(16'h0020, 16'h2020); upd(16'h0030, 16'h3030);
    req = "R3"; look(16'h0010);
    req = "R4"; look(16'h0010); look(16'h0030);
    req = "R8"; upd(16'h0040, 16'h4040); upd(16'h0050, 16'h5050); upd(16'h0060, 16'h6060);
    look(16'h0010); look(16'h0020); look(16'h0060);
    req = "R9";
    cyc(1, 16'h0060, 1, 16'h0060, 16'h6161); idle(2); look(16'h0060);
    cyc(1, 16'h0050, 0, '0, '0); cyc(0, 16'h0050, 1, 16'h0070, 16'h7070); idle(1);
    look(16'h0050);
    req = "R10";
    cyc(1, 16'h0080, 0, '0, '0); cyc(1, 16'h0060, 0, '0, '0); cyc(1, 16'h0060, 0, '0, '0); idle(2);
    req = "R9";
    lv = 0; lpc = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!(lv && !m_acc)) begin
        lv  = ($urandom_range(0, 2) != 0);
        lpc = AW'($urandom_range(0, 47));
      end
      cyc(lv, lpc, ($urandom_range(0, 3) == 0), AW'($urandom_range(0, 47)), AW'($urandom));
    end
    idle(3);
    finish_run();
  end
endmodule